// File: doc/BRIEF.md
# PHY Control-Port Write Engine

This block drives the parallel control-register port of two PCIe PHYs. Each access is a single 16-bit register write. The engine sets up the address and data, raises the write strobe, waits for the PHY's acknowledge to rise, drops the strobe, and then waits for the acknowledge to fall. Both acknowledge waits are checked against the acknowledge on a fixed polling interval, and each wait has a limit. If a wait reaches its limit, the engine raises a warning and carries on instead of stalling.

Two kinds of operation are started from an idle engine. A built-in initialisation pass writes the receiver-override configuration word 0x0E21 into every lane of both PHYs. A single-write request writes one caller-chosen word to one caller-chosen PHY. On the first operation after reset, both PHY select lines go high, and no strobe is raised until a settle window has passed. A one-cycle `done` pulse closes every operation. A sticky `warn` flag records any timeout and is cleared when the next operation is accepted.

Top module: `phycw_engine`

## Requirements
- R1: While reset is active and right after it, `phy_sel`, `phy_wen`, `busy`, `done` and `warn` are all 0.
- R2: Both select lines rise on the first accepted operation and stay high. No write strobe rises until the selects have been high for at least SETTLE_CYC cycles.
- R3: The initialisation pass performs 8 writes, all with data 0x0E21 (bits 0, 5, 9, 10 and 11 set). The order is PHY 0 lanes 0..3, then PHY 1 lanes 0..3, and the address for lane n is 0x1008 + 0x100·n.
- R4: A write strobe rises only while that PHY's acknowledge is low. With a responding PHY, the strobe falls only after the acknowledge has been high.
- R5: At most one PHY's strobe is high at a time. The PHY not being addressed sees strobe 0, address 0 and data 0.
- R6: Address and data on the addressed PHY stay constant from the rising strobe until that PHY's acknowledge has fallen.
- R7: If the acknowledge never rises, the strobe is dropped after POLL_LIMIT polls of POLL_CYC cycles each. `warn` is set and the remaining writes still run.
- R8: If the acknowledge never falls after the strobe drops, the operation ends after POLL_LIMIT polls. `done` still pulses and `warn` is set.
- R9: `done` is a single-cycle pulse, given once per operation, after the last write's handshake. `busy` is high from acceptance until that pulse.
- R10: `warn` holds once set, through idle time, and is cleared in the cycle an operation is accepted.
- R11: A single-write request (`wr_req` with `wr_phy`, `wr_addr`, `wr_data`) performs exactly one write of that data at that address on that PHY.
- R12: `init_start` and `wr_req` are ignored while `busy` is high. When both arrive together at an idle engine, the initialisation pass runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_start | input | 1 | Start the 8-write initialisation pass |
| wr_req | input | 1 | Start a single write |
| wr_phy | input | PHY_W | PHY index for the single write |
| wr_addr | input | 16 | Register address for the single write |
| wr_data | input | 16 | Data word for the single write |
| phy_ack | input | NPHY | Acknowledge from each PHY |
| phy_sel | output | NPHY | Control-port select to each PHY |
| phy_addr | output | NPHY×16 | Per-PHY register address, PHY p at bits 16p+15..16p |
| phy_wdata | output | NPHY×16 | Per-PHY write data, same packing |
| phy_wen | output | NPHY | Per-PHY write strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| warn | output | 1 | Sticky handshake-timeout warning |

## Verification
The initialisation pass is first run against PHY models that answer promptly with random delays. This separates a correct write order and address arithmetic from faults that swap lanes, PHYs or data bits. Random single writes to random PHYs with random words check that the caller's fields reach the right port and that the idle port stays at zero. In the directed cases, one PHY is muted so its acknowledge never rises, and another holds its acknowledge high. These cases separate the rise timeout from the fall timeout and show that the sequence goes on after a timeout. Requests made while busy, and simultaneous requests, show the ignore rule and the priority rule.

// File: rtl/phycw_pkg.sv
package phycw_pkg;

  localparam logic [15:0] LANE_REG_BASE = 16'h1008;
  localparam logic [15:0] LANE_REG_STEP = 16'h0100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PRESENT,
    ST_WAIT_HI,
    ST_WAIT_LO
  } cw_state_e;

  // receive-override register address of a lane
  function automatic logic [15:0] lane_reg_addr(input int lane);
    return LANE_REG_BASE + LANE_REG_STEP * 16'(lane);
  endfunction

  // configuration word: PHY enable, AC/DC termination, termination enable,
  // loss-of-signal threshold, clock-recovery tracking
  function automatic logic [15:0] rx_cfg_word();
    logic [15:0] w;
    w = '0;
    w[11] = 1'b1;
    w[10] = 1'b1;
    w[9]  = 1'b1;
    w[5]  = 1'b1;
    w[0]  = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/phycw_sync.sv
module phycw_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/phycw_pacer.sv
module phycw_pacer #(
  parameter int POLL_CYC   = 500,
  parameter int POLL_LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick,
  output logic last
);
  localparam int DIV_W = $clog2(POLL_CYC + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] polls_q;

  assign tick = (div_q == DIV_W'(POLL_CYC - 1));
  assign last = (polls_q == CNT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      polls_q <= '0;
    end else if (restart) begin
      div_q   <= '0;
      polls_q <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (!last) polls_q <= polls_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    polls_q < CNT_W'(POLL_LIMIT));
endmodule

// File: rtl/phycw_initseq.sv
module phycw_initseq
  import phycw_pkg::*;
#(
  parameter int NPHY  = 2,
  parameter int NLANE = 4,
  parameter int PHY_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic [PHY_W-1:0] phy,
  output logic [15:0]      addr,
  output logic [15:0]      data,
  output logic             last
);
  localparam int STEPS = NPHY * NLANE;
  localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idx_q <= '0;
    else if (load)             idx_q <= '0;
    else if (adv && !last)     idx_q <= idx_q + 1'b1;
  end

  assign phy  = PHY_W'(int'(idx_q) / NLANE);
  assign addr = lane_reg_addr(int'(idx_q) % NLANE);
  assign data = rx_cfg_word();
  assign last = (idx_q == IDX_W'(STEPS - 1));
endmodule

// File: rtl/phycw_engine.sv
module phycw_engine
  import phycw_pkg::*;
#(
  parameter int NPHY       = 2,
  parameter int NLANE      = 4,
  parameter int POLL_CYC   = 500,
  parameter int POLL_LIMIT = 500,
  parameter int SETTLE_CYC = 10,
  localparam int PHY_W     = (NPHY > 1) ? $clog2(NPHY) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_start,
  input  logic              wr_req,
  input  logic [PHY_W-1:0]  wr_phy,
  input  logic [15:0]       wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [NPHY-1:0]   phy_ack,
  output logic [NPHY-1:0]   phy_sel,
  output logic [NPHY*16-1:0] phy_addr,
  output logic [NPHY*16-1:0] phy_wdata,
  output logic [NPHY-1:0]   phy_wen,
  output logic              busy,
  output logic              done,
  output logic              warn
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  cw_state_e state_q;
  logic [SET_W-1:0] settle_q;
  logic sel_q, settled_q, init_mode_q, done_q, warn_q;
  logic [PHY_W-1:0] one_phy_q;
  logic [15:0] one_addr_q, one_data_q;

  logic [NPHY-1:0] ack_s;
  logic tick, poll_last, restart;
  logic [PHY_W-1:0] seq_phy, cur_phy;
  logic [15:0] seq_addr, seq_data, cur_addr, cur_data;
  logic seq_last, seq_adv;

  // named internal events
  logic start_init_acc, start_wr_acc, start_acc;
  logic ack_cur, hi_ok, hi_to, lo_ok, lo_to, lo_exit, op_end, hs_active;

  phycw_sync #(.W(NPHY)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(phy_ack), .dout(ack_s)
  );

  phycw_pacer #(.POLL_CYC(POLL_CYC), .POLL_LIMIT(POLL_LIMIT)) u_pacer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .last(poll_last)
  );

  phycw_initseq #(.NPHY(NPHY), .NLANE(NLANE), .PHY_W(PHY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(start_init_acc), .adv(seq_adv),
    .phy(seq_phy), .addr(seq_addr), .data(seq_data), .last(seq_last)
  );

  assign start_init_acc = (state_q == ST_IDLE) && init_start;
  assign start_wr_acc   = (state_q == ST_IDLE) && wr_req && !init_start;
  assign start_acc      = start_init_acc || start_wr_acc;

  assign cur_phy  = init_mode_q ? seq_phy  : one_phy_q;
  assign cur_addr = init_mode_q ? seq_addr : one_addr_q;
  assign cur_data = init_mode_q ? seq_data : one_data_q;

  assign ack_cur  = ack_s[cur_phy];
  assign hi_ok    = (state_q == ST_WAIT_HI) && tick && ack_cur;
  assign hi_to    = (state_q == ST_WAIT_HI) && tick && !ack_cur && poll_last;
  assign lo_ok    = (state_q == ST_WAIT_LO) && tick && !ack_cur;
  assign lo_to    = (state_q == ST_WAIT_LO) && tick && ack_cur && poll_last;
  assign lo_exit  = lo_ok || lo_to;
  assign seq_adv  = lo_exit && init_mode_q && !seq_last;
  assign op_end   = lo_exit && !(init_mode_q && !seq_last);
  assign restart  = (state_q == ST_PRESENT) || hi_ok || hi_to;
  assign hs_active = (state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      settle_q    <= '0;
      sel_q       <= 1'b0;
      settled_q   <= 1'b0;
      init_mode_q <= 1'b0;
      done_q      <= 1'b0;
      warn_q      <= 1'b0;
      one_phy_q   <= '0;
      one_addr_q  <= '0;
      one_data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_acc) begin
            sel_q       <= 1'b1;
            warn_q      <= 1'b0;
            init_mode_q <= start_init_acc;
            state_q     <= settled_q ? ST_PRESENT : ST_SETTLE;
            if (start_wr_acc) begin
              one_phy_q  <= wr_phy;
              one_addr_q <= wr_addr;
              one_data_q <= wr_data;
            end
          end
        end
        ST_SETTLE: begin
          if (settle_q == SET_W'(SETTLE_CYC - 1)) begin
            settled_q <= 1'b1;
            state_q   <= ST_PRESENT;
          end else begin
            settle_q <= settle_q + 1'b1;
          end
        end
        ST_PRESENT: state_q <= ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (hi_ok || hi_to) state_q <= ST_WAIT_LO;
          if (hi_to) warn_q <= 1'b1;
        end
        ST_WAIT_LO: begin
          if (lo_to) warn_q <= 1'b1;
          if (seq_adv) state_q <= ST_PRESENT;
          if (op_end) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NPHY; p++) begin : g_port
    logic mine;
    assign mine                 = (cur_phy == PHY_W'(p));
    assign phy_wen[p]           = mine && (state_q == ST_WAIT_HI);
    assign phy_addr[p*16 +: 16]  = mine ? cur_addr : 16'h0000;
    assign phy_wdata[p*16 +: 16] = mine ? cur_data : 16'h0000;
  end

  assign phy_sel = {NPHY{sel_q}};
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign warn    = warn_q;

  p_one_wen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_wen));
  p_sel_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|phy_wen) |-> (&phy_sel));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_active && $past(hs_active)) |-> ($stable(cur_addr) && $stable(cur_data)));
  p_drop_on_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hi_to |=> !(|phy_wen));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_warn_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warn && !start_acc) |=> warn);
endmodule

// File: tb/phycw_engine_tb_top.sv
module phycw_engine_tb_top;
  localparam int NPHY = 2;
  localparam int NLANE = 4;
  localparam int PC = 4;
  localparam int PL = 6;
  localparam int SC = 10;
  localparam int TO = PC * PL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_start = 1'b0, wr_req = 1'b0;
  logic [0:0] wr_phy = '0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic [NPHY-1:0] phy_ack = '0;
  logic [NPHY-1:0] phy_sel, phy_wen;
  logic [NPHY*16-1:0] phy_addr, phy_wdata;
  logic busy, done, warn;

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  phycw_engine #(.NPHY(NPHY), .NLANE(NLANE), .POLL_CYC(PC), .POLL_LIMIT(PL),
    .SETTLE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .init_start(init_start), .wr_req(wr_req),
    .wr_phy(wr_phy), .wr_addr(wr_addr), .wr_data(wr_data), .phy_ack(phy_ack),
    .phy_sel(phy_sel), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_wen(phy_wen), .busy(busy), .done(done), .warn(warn)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [0:0] exp_phy(input int i);
    return 1'(i / NLANE);
  endfunction
  function automatic logic [15:0] exp_addr(input int i);
    return {8'(8'h10 + i % NLANE), 8'h08};
  endfunction
  function automatic logic [15:0] exp_word();
    return 16'd3617;
  endfunction

  // PHY models
  int dly [NPHY];
  int acnt [NPHY];
  bit mute [NPHY];
  bit stuck [NPHY];
  always @(posedge clk) begin
    logic tgt;
    for (int p = 0; p < NPHY; p++) begin
      tgt = mute[p] ? 1'b0 : (phy_wen[p] | (stuck[p] & phy_ack[p]));
      if (phy_ack[p] != tgt) begin
        if (acnt[p] >= dly[p]) begin
          phy_ack[p] <= tgt;
          acnt[p] <= 0;
        end else acnt[p] <= acnt[p] + 1;
      end else acnt[p] <= 0;
    end
  end

  // monitor
  logic [0:0] log_p [64];
  logic [15:0] log_a [64];
  logic [15:0] log_d [64];
  int nlog = 0;
  int sel_cnt = 0;
  int hi_len [NPHY];
  int last_hi [NPHY];
  bit live [NPHY];
  logic [15:0] live_a [NPHY];
  logic [15:0] live_d [NPHY];
  logic [NPHY-1:0] prev_wen = '0;
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R9 done wider than one cycle", 1, 0);
      for (int p = 0; p < NPHY; p++) begin
        if (phy_wen[p] && !prev_wen[p]) begin
          log_p[nlog % 64] = 1'(p);
          log_a[nlog % 64] = phy_addr[p*16 +: 16];
          log_d[nlog % 64] = phy_wdata[p*16 +: 16];
          nlog++;
          chk((&phy_sel) && sel_cnt >= SC, "R2 select settle before strobe",
              sel_cnt, SC);
          chk(phy_ack[p] == 1'b0, "R4 ack low at strobe rise", phy_ack[p], 0);
          chk(phy_wen[1-p] == 1'b0 && phy_addr[(1-p)*16 +: 16] == 16'h0 &&
              phy_wdata[(1-p)*16 +: 16] == 16'h0, "R5 other port idle",
              {phy_addr[(1-p)*16 +: 16], phy_wdata[(1-p)*16 +: 16]}, 0);
          live[p] = 1'b1;
          live_a[p] = phy_addr[p*16 +: 16];
          live_d[p] = phy_wdata[p*16 +: 16];
          hi_len[p] = 1;
        end else if (phy_wen[p]) begin
          hi_len[p]++;
        end else if (prev_wen[p]) begin
          last_hi[p] = hi_len[p];
          if (!mute[p]) chk(phy_ack[p] == 1'b1, "R4 ack seen before strobe fall",
                            phy_ack[p], 1);
        end
        if (live[p]) begin
          if (phy_addr[p*16 +: 16] != live_a[p] || phy_wdata[p*16 +: 16] != live_d[p])
            chk(1'b0, "R6 address/data held during handshake",
                {phy_addr[p*16 +: 16], phy_wdata[p*16 +: 16]}, {live_a[p], live_d[p]});
          if (!phy_wen[p] && !phy_ack[p]) live[p] = 1'b0;
        end
      end
      sel_cnt = (&phy_sel) ? sel_cnt + 1 : 0;
      prev_wen = phy_wen;
      prev_done = done;
    end
  end

  task automatic pulse_init(input bit with_wr);
    @(negedge clk);
    init_start = 1'b1;
    wr_req = with_wr;
    @(negedge clk);
    init_start = 1'b0;
    wr_req = 1'b0;
  endtask

  task automatic pulse_wr(input logic [0:0] p, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_req = 1'b1; wr_phy = p; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic wait_done(output bit got, output int cyc);
    got = 1'b0;
    cyc = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
      cyc++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    bit got;
    int cyc, base;
    logic [0:0] rp;
    logic [15:0] ra, rd;
    void'($urandom(32'h5EED_0C0D));
    for (int p = 0; p < NPHY; p++) begin
      dly[p] = 1; acnt[p] = 0; mute[p] = 0; stuck[p] = 0;
      hi_len[p] = 0; last_hi[p] = 0; live[p] = 0; live_a[p] = 0; live_d[p] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(phy_sel == 0 && phy_wen == 0 && !busy && !done && !warn,
        "R1 reset outputs", {phy_sel, phy_wen, busy, done, warn}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phy_sel == 0 && phy_wen == 0 && !busy && !done && !warn,
        "R1 outputs after reset", {phy_sel, phy_wen, busy, done, warn}, 0);

    // R3 init pass
    base = nlog;
    pulse_init(1'b0);
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    wait_done(got, cyc);
    chk(got, "R9 done after init", got, 1);
    chk(nlog - base == 8, "R3 init write count", nlog - base, 8);
    for (int i = 0; i < 8; i++) begin
      chk(log_p[(base + i) % 64] == exp_phy(i) && log_a[(base + i) % 64] == exp_addr(i)
          && log_d[(base + i) % 64] == exp_word(), "R3 init write contents",
          {log_p[(base + i) % 64], log_a[(base + i) % 64]}, {exp_phy(i), exp_addr(i)});
    end
    chk(!warn, "R7 no warning with responsive PHYs", warn, 0);

    // R11 random singles
    for (int k = 0; k < 16; k++) begin
      for (int p = 0; p < NPHY; p++) dly[p] = int'($urandom % 4);
      rp = 1'($urandom);
      ra = 16'($urandom);
      rd = 16'($urandom);
      base = nlog;
      pulse_wr(rp, ra, rd);
      wait_done(got, cyc);
      chk(got && nlog - base == 1, "R11 single write count", nlog - base, 1);
      chk(log_p[base % 64] == rp && log_a[base % 64] == ra && log_d[base % 64] == rd,
          "R11 single write contents", {log_p[base % 64], log_a[base % 64], log_d[base % 64]},
          {rp, ra, rd});
      chk(!warn, "R11 no warning", warn, 0);
    end

    // R12 requests while busy are ignored
    base = nlog;
    pulse_wr(1'b1, 16'hABCD, 16'h1234);
    chk(busy, "R12 busy during write", busy, 1);
    wr_req = 1'b1; init_start = 1'b1; wr_phy = 1'b0; wr_addr = 16'h5555; wr_data = 16'h6666;
    @(negedge clk);
    wr_req = 1'b0; init_start = 1'b0;
    wait_done(got, cyc);
    repeat (40) @(negedge clk);
    chk(nlog - base == 1 && log_a[base % 64] == 16'hABCD && log_p[base % 64] == 1'b1,
        "R12 busy requests ignored", nlog - base, 1);

    // R12 priority of init over single write
    base = nlog;
    pulse_init(1'b1);
    wait_done(got, cyc);
    chk(nlog - base == 8 && log_a[base % 64] == exp_addr(0) && log_p[base % 64] == 1'b0,
        "R12 init wins simultaneous start", nlog - base, 8);

    // R7 muted PHY 1: rise timeout, sequence continues
    mute[1] = 1;
    base = nlog;
    pulse_init(1'b0);
    wait_done(got, cyc);
    chk(got, "R7 done despite timeouts", got, 1);
    chk(nlog - base == 8 && log_a[(base + 7) % 64] == exp_addr(7),
        "R7 all writes issued", nlog - base, 8);
    chk(warn, "R7 warning set", warn, 1);
    chk(last_hi[1] >= TO - 1 && last_hi[1] <= TO + 1, "R7 strobe length at timeout",
        last_hi[1], TO);
    mute[1] = 0;
    repeat (30) @(negedge clk);
    chk(warn, "R10 warning held while idle", warn, 1);
    pulse_wr(1'b0, 16'h0042, 16'h0F0F);
    chk(!warn && busy, "R10 warning cleared on accept", warn, 0);
    wait_done(got, cyc);
    chk(!warn, "R10 clean write keeps warning clear", warn, 0);

    // R8 acknowledge stuck high
    stuck[0] = 1;
    pulse_wr(1'b0, 16'h0777, 16'h0888);
    wait_done(got, cyc);
    chk(got, "R8 done after fall timeout", got, 1);
    chk(warn, "R8 warning set", warn, 1);
    chk(cyc >= TO, "R8 operation lasts past fall limit", cyc, TO);
    stuck[0] = 0;
    repeat (20) @(negedge clk);
    chk(phy_ack == 0, "R8 ack released", phy_ack, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule